// File: doc/BRIEF.md
# Index-Weighted Dot Product Engine

This block forms the dot product of a set of weight/activation tuples without a multiplier. The weight of each tuple is used as an address into a slot store. The activation is added into the slot that the weight selects. The position of a slot is its implicit multiplier. Tuples may be loaded one per clock, in any order. Tuples that share a weight accumulate in the same slot. While loading, the block tracks the highest index written.

On a start pulse, a sequencer sweeps the slots from that highest index down to one, taking one slot per clock. A running height register collects the slot contents seen so far. An accumulator adds the height on every step, so after the sweep it holds the sum of index times slot content, formed with adders only. The sweep length follows the data, so a run with small indices ends sooner. A completion flag marks the clock in which the result becomes valid. A parameter chooses whether the accumulator adds the registered height, which gives a shorter path at the cost of one more clock, or the freshly summed height.

Top module: `madd_dot_engine`

## Requirements
- R1: An accepted load adds `load_act` into the slot selected by `load_idx`. Loads with the same index accumulate in one slot, and the order of loading does not change the result.
- R2: On completion, `result` equals the sum over k from 1 to 2^IDX_W-1 of k times the content of slot k. Slot positions count from one.
- R3: With HEIGHT_REG=1, `done` rises after M+2 rising edges counted from the edge that accepts `start`, including that edge, where M is the highest index loaded since the last clear. With HEIGHT_REG=0 it rises after M+1 edges. `done` and `result` then hold until the next accepted start or clear.
- R4: A `start` pulse that arrives during a sweep is ignored. The running sweep keeps its length and its result.
- R5: A load presented during a sweep, or in the same cycle as an accepted start, is ignored. It changes neither the slot contents nor the highest index.
- R6: A load with `load_idx` = 0 is rejected. It writes no slot and does not change the highest index.
- R7: If no tuple has been accepted since the last clear, `done` is high after the start edge itself, with `result` = 0.
- R8: A `clear` pulse zeroes all slots, the highest index, the height, the accumulator, `result` and `done`, and it aborts a running sweep.
- R9: After reset, `done` is 0, `result` is 0 and the slot store is empty.
- R10: With MAX_TUPLES tuples of full-scale activation at the highest index, no slot or accumulator overflows and the result is exact.
- R11: A sweep leaves the slots untouched, so a second start without a clear returns the same result after the same number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous clear of slots, index tracker and result |
| load_valid | input | 1 | A tuple is presented this cycle |
| load_idx | input | IDX_W | Weight of the tuple, which is the slot index |
| load_act | input | ACT_W | Activation of the tuple, unsigned |
| start | input | 1 | Begin a sweep over the loaded slots |
| result | output | ACC_W | Dot product, registered |
| done | output | 1 | High while `result` holds a completed dot product |

## Verification
The main function is tried with scattered distinct indices, with repeated indices, and with the same tuples in reversed order. A weight or ordering bug changes the sum even when the sweep length is right. Each run checks the latency as well as the value, so a sweep that starts from the wrong index or stops at zero instead of one shows up as an off-by-one cycle count. An empty store, index-zero-only loads, a full-scale load at the top index, and starts and loads injected mid-sweep show apart the empty shortcut, rejection, overflow and busy-protection paths. Repeated runs after a sweep and after a clear show whether the slots are kept or wiped.

// File: rtl/madd_pkg.sv
package madd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_TAIL  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/madd_slot_array.sv
module madd_slot_array #(
  parameter int IDX_W   = 4,
  parameter int ACT_W   = 8,
  parameter int ENTRY_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ACT_W-1:0]   wr_act,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENTRY_W-1:0] slots [DEPTH];
  logic [ENTRY_W-1:0] wr_sum;

  // read-modify-write: same-index loads on back-to-back cycles chain correctly
  assign wr_sum  = slots[wr_idx] + ENTRY_W'(wr_act);
  assign rd_data = slots[rd_idx];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (wr_en) begin
      slots[wr_idx] <= wr_sum;
    end
  end

  // R6: the load gate upstream never lets index zero through
  a_r6_no_zero_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx != '0));
endmodule

// File: rtl/madd_peak_tracker.sv
module madd_peak_tracker #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             upd,
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] peak
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      peak <= '0;
    end else if (upd && (idx > peak)) begin
      peak <= idx;
    end
  end

  // R3: the sweep bound only grows between clears
  a_r3_peak_monotonic: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (peak >= $past(peak)));
endmodule

// File: rtl/madd_sweep_core.sv
module madd_sweep_core #(
  parameter int ENTRY_W    = 12,
  parameter int ACC_W      = 20,
  parameter bit HEIGHT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               init,
  input  logic               step,
  input  logic [ENTRY_W-1:0] entry,
  output logic [ACC_W-1:0]   fin_sum
);
  logic [ACC_W-1:0] height_q, total_q;
  logic [ACC_W-1:0] entry_x, height_nx, total_nx;

  assign entry_x   = ACC_W'(entry);
  assign height_nx = height_q + entry_x;

  generate
    if (HEIGHT_REG) begin : g_reg_height
      // accumulator adds the registered height: one adder deep, one extra fold
      assign total_nx = total_q + height_q;
      assign fin_sum  = total_q + height_q;
    end else begin : g_direct_height
      // accumulator adds the fresh height: two adders in series, no fold
      assign total_nx = total_q + height_nx;
      assign fin_sum  = total_nx;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr || init) begin
      height_q <= '0;
      total_q  <= '0;
    end else if (step) begin
      height_q <= height_nx;
      total_q  <= total_nx;
    end
  end

  // R2: height is a running sum of unsigned slots and never decreases in a sweep
  a_r2_height_grows: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && !init) |=> (height_q >= $past(height_q)));
  // R2: the accumulator never falls during a sweep either
  a_r2_total_grows: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && !init) |=> (total_q >= $past(total_q)));
endmodule

// File: rtl/madd_dot_engine.sv
module madd_dot_engine
  import madd_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int ACT_W      = 8,
  parameter int MAX_TUPLES = 16,
  parameter bit HEIGHT_REG = 1'b1,
  localparam int CNT_W     = $clog2(MAX_TUPLES),
  localparam int ENTRY_W   = ACT_W + CNT_W,
  localparam int ACC_W     = ACT_W + 2 * IDX_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load_valid,
  input  logic [IDX_W-1:0] load_idx,
  input  logic [ACT_W-1:0] load_act,
  input  logic             start,
  output logic [ACC_W-1:0] result,
  output logic             done
);
  seq_state_t         state_q;
  logic [IDX_W-1:0]   k_q;
  logic [IDX_W-1:0]   peak;
  logic [ENTRY_W-1:0] slot_rd;
  logic [ACC_W-1:0]   fin_sum;
  logic               busy, start_ok, load_ok, sweeping, last_step;

  assign busy      = (state_q != ST_IDLE);
  assign start_ok  = start && !busy && !clear;
  assign load_ok   = load_valid && (load_idx != '0) && !busy && !start_ok && !clear;
  assign sweeping  = (state_q == ST_SWEEP);
  assign last_step = sweeping && (k_q == IDX_W'(1));

  madd_slot_array #(
    .IDX_W  (IDX_W),
    .ACT_W  (ACT_W),
    .ENTRY_W(ENTRY_W)
  ) u_slots (
    .clk    (clk),
    .rst    (rst),
    .clr    (clear),
    .wr_en  (load_ok),
    .wr_idx (load_idx),
    .wr_act (load_act),
    .rd_idx (k_q),
    .rd_data(slot_rd)
  );

  madd_peak_tracker #(
    .IDX_W(IDX_W)
  ) u_peak (
    .clk (clk),
    .rst (rst),
    .clr (clear),
    .upd (load_ok),
    .idx (load_idx),
    .peak(peak)
  );

  madd_sweep_core #(
    .ENTRY_W   (ENTRY_W),
    .ACC_W     (ACC_W),
    .HEIGHT_REG(HEIGHT_REG)
  ) u_core (
    .clk    (clk),
    .rst    (rst),
    .clr    (clear),
    .init   (start_ok),
    .step   (sweeping),
    .entry  (slot_rd),
    .fin_sum(fin_sum)
  );

  // sequencer: IDLE -> SWEEP (peak .. 1) -> [TAIL] -> IDLE
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            if (peak == '0) begin
              done   <= 1'b1;
              result <= '0;
            end else begin
              done    <= 1'b0;
              state_q <= ST_SWEEP;
              k_q     <= peak;
            end
          end
        end
        ST_SWEEP: begin
          k_q <= k_q - IDX_W'(1);
          if (last_step) begin
            if (HEIGHT_REG) begin
              state_q <= ST_TAIL;
            end else begin
              state_q <= ST_IDLE;
              done    <= 1'b1;
              result  <= fin_sum;
            end
          end
        end
        ST_TAIL: begin
          state_q <= ST_IDLE;
          done    <= 1'b1;
          result  <= fin_sum;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7: empty store completes on the start edge with zero
  a_r7_empty_done: assert property (@(posedge clk) disable iff (rst)
    (start_ok && (peak == '0)) |=> (done && (result == '0)));
  // R3: the sweep begins at the highest loaded index
  a_r3_first_index: assert property (@(posedge clk) disable iff (rst)
    (start_ok && (peak != '0)) |=> (sweeping && (k_q == $past(peak))));
  // R4: a sweep steps down by one each clock whatever start does
  a_r4_sweep_continues: assert property (@(posedge clk) disable iff (rst)
    (sweeping && (k_q > IDX_W'(1)) && !clear) |=>
      (sweeping && (k_q == $past(k_q) - IDX_W'(1))));
  // R5: the highest index is frozen while busy
  a_r5_peak_frozen_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && !clear) |=> (peak == $past(peak)));
  // R8: clear drops the result and the completion flag
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clear |=> (!done && (result == '0) && (peak == '0)));
  // R3: done never rises in the middle of a sweep
  a_r3_done_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !busy);
endmodule

// File: tb/tb_madd_dot_engine.sv
module tb_madd_dot_engine;
  localparam int IDX_W      = 4;
  localparam int ACT_W      = 8;
  localparam int MAX_TUPLES = 16;
  localparam bit HREG       = 1'b1;
  localparam int ACC_W      = ACT_W + 2 * IDX_W + $clog2(MAX_TUPLES);
  localparam int DEPTH      = 1 << IDX_W;
  localparam int EXTRA      = HREG ? 2 : 1;

  logic             clk = 1'b0;
  logic             rst, clear, load_valid, start;
  logic [IDX_W-1:0] load_idx;
  logic [ACT_W-1:0] load_act;
  logic [ACC_W-1:0] result;
  logic             done;

  int checks = 0;
  int errors = 0;
  int model [DEPTH];
  int model_max = 0;

  always #5 clk = ~clk;

  madd_dot_engine #(
    .IDX_W     (IDX_W),
    .ACT_W     (ACT_W),
    .MAX_TUPLES(MAX_TUPLES),
    .HEIGHT_REG(HREG)
  ) dut (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .load_valid(load_valid),
    .load_idx  (load_idx),
    .load_act  (load_act),
    .start     (start),
    .result    (result),
    .done      (done)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint model_sum();
    longint s = 0;
    for (int k = 1; k < DEPTH; k++) s += longint'(k) * longint'(model[k]);
    return s;
  endfunction

  function automatic int model_lat();
    return (model_max == 0) ? 1 : model_max + EXTRA;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) model[i] = 0;
    model_max = 0;
  endtask

  task automatic load_tuple(input int idx, input int act);
    @(negedge clk);
    load_valid = 1'b1;
    load_idx   = IDX_W'(idx);
    load_act   = ACT_W'(act);
    @(negedge clk);
    load_valid = 1'b0;
    if (idx != 0) begin
      model[idx] += act;
      if (idx > model_max) model_max = idx;
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    model_clear();
  endtask

  // start a sweep, optionally disturb it mid-way with a start and a load
  task automatic run_check(input string req, input bit disturb);
    int cycles = 0;
    longint exp_sum = model_sum();
    int exp_lat = model_lat();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!done && cycles < 200) begin
      @(negedge clk);
      cycles++;
      if (disturb && cycles == 2) begin
        start = 1'b1; load_valid = 1'b1; load_idx = IDX_W'(DEPTH - 1); load_act = 8'd50;
      end else if (disturb && cycles == 3) begin
        start = 1'b0; load_valid = 1'b0;
      end
    end
    check(req, "done", longint'(done), 1);
    check(req, "latency", cycles, exp_lat);
    check(req, "result", longint'(result), exp_sum);
    @(negedge clk);
    check("R3", "done held", longint'(done), 1);
    check("R3", "result held", longint'(result), exp_sum);
  endtask

  task automatic t_reset();
    check("R9", "done after reset", longint'(done), 0);
    check("R9", "result after reset", longint'(result), 0);
    run_check("R9", 1'b0);
  endtask

  task automatic t_basic();
    do_clear();
    load_tuple(3, 10); load_tuple(1, 7); load_tuple(5, 2);
    run_check("R2", 1'b0);
    check("R2", "basic sum", longint'(result), 47);
  endtask

  task automatic t_repeat_idx();
    do_clear();
    load_tuple(4, 100); load_tuple(2, 255); load_tuple(4, 50);
    run_check("R1", 1'b0);
    check("R1", "accumulated sum", longint'(result), 1110);
  endtask

  task automatic t_reorder();
    do_clear();
    load_tuple(4, 50); load_tuple(4, 100); load_tuple(2, 255);
    run_check("R1", 1'b0);
    check("R1", "reordered sum", longint'(result), 1110);
  endtask

  task automatic t_zero_idx();
    do_clear();
    load_tuple(0, 200);
    run_check("R6", 1'b0);
    load_tuple(0, 99); load_tuple(2, 3);
    run_check("R6", 1'b0);
  endtask

  task automatic t_empty();
    do_clear();
    run_check("R7", 1'b0);
  endtask

  task automatic t_full_scale();
    do_clear();
    for (int i = 0; i < MAX_TUPLES; i++) load_tuple(DEPTH - 1, 255);
    run_check("R10", 1'b0);
    check("R10", "full-scale sum", longint'(result), 61200);
  endtask

  task automatic t_busy();
    do_clear();
    load_tuple(5, 9); load_tuple(2, 4); load_tuple(1, 1);
    run_check("R4", 1'b1);
    // R5: the mid-sweep load at the top index must not have landed
    run_check("R5", 1'b0);
    check("R5", "ignored load", longint'(result), 54);
  endtask

  task automatic t_rerun();
    do_clear();
    load_tuple(6, 11); load_tuple(3, 20);
    run_check("R11", 1'b0);
    run_check("R11", 1'b0);
  endtask

  task automatic t_clear();
    do_clear();
    load_tuple(7, 30);
    run_check("R8", 1'b0);
    do_clear();
    check("R8", "done after clear", longint'(done), 0);
    check("R8", "result after clear", longint'(result), 0);
    run_check("R8", 1'b0);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    rst = 1'b1; clear = 1'b0; load_valid = 1'b0; start = 1'b0;
    load_idx = '0; load_act = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_repeat_idx();
    t_reorder();
    t_zero_idx();
    t_empty();
    t_full_scale();
    t_busy();
    t_rerun();
    t_clear();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule